// File: doc/BRIEF.md
# Dual-Processor Mailbox Flag Controller

This block gives two processors a lock-free way to hand over ownership of mailboxes held in a shared memory outside the block. Each direction (processor 1 to processor 2, and back) has `NCH` channels, six by default. Each channel is one flag: 0 means free, so the sender may write the mailbox; 1 means occupied, so the receiver may read it. A sender marks its mailbox occupied after posting data. The receiver marks it free again after consuming the data.

Each processor has four word registers: an interrupt control word, a mask word, a write-one set/clear strobe word and a read-only view of its transmit flags. A processor can only set the flags it transmits on and only clear the flags it receives on. Four level interrupts are built from the flags, the per-channel masks and the two enables in each control word. The RX-occupied interrupt tells a processor that mail is waiting. The TX-free interrupt tells it that a mailbox it is waiting on has been released.

The bus is a simple single-cycle register port with 3-bit word addressing and a size code. Only full-word accesses have any effect. Read data is registered and valid in the cycle after the request.

Top module: `mbox_flag_ctrl`

## Requirements
- R1: After reset, every control word reads 0, every mask word reads 0x003F003F, every set/clear word reads 0, every status word reads 0, and all four interrupts are low.
- R2: Word address bit 2 selects the processor (0 = processor 1, 1 = processor 2). Address bits 1:0 select the role: 0 control, 1 mask, 2 set/clear, 3 status. The status word of processor p shows the flags that p transmits on. Control bit 16 is the TX-free enable and bit 0 is the RX-occupied enable. Mask bits 21:16 are the free masks of p's transmit channels and bits 5:0 are the occupied masks of p's receive channels.
- R3: Writing 1 to bit 16+k of processor p's set/clear word sets flag k of p's transmit direction and no flag of the other direction.
- R4: Writing 1 to bit k of processor p's set/clear word clears flag k of the other processor's transmit direction. Bits written as 0 leave their flags unchanged, and a set and a clear in the same word both act.
- R5: Set/clear words always read 0. Status words are read-only, so a write to them changes nothing.
- R6: A processor's RX-occupied interrupt is high when its RX enable is 1 and at least one of its receive channels has flag 1 with occupied mask 0. Otherwise it is low.
- R7: A processor's TX-free interrupt is high when its TX enable is 1 and at least one of its transmit channels has flag 0 with free mask 0. Otherwise it is low.
- R8: Only accesses with size code 2 (word) act. Size codes 0 (byte), 1 (half-word) and 3 leave all state unchanged on writes and return 0 on reads.
- R9: Reserved bits of every word read as 0, and writes to them have no effect.
- R10: A word write updates state at the clock edge that accepts it, so a read issued in the next cycle sees the new value. The interrupt outputs change one clock edge after the state they depend on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request, sampled on each rising edge |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the request |
| cpu1_txfree_irq | output | 1 | Processor 1 TX-free interrupt |
| cpu1_rxocc_irq | output | 1 | Processor 1 RX-occupied interrupt |
| cpu2_txfree_irq | output | 1 | Processor 2 TX-free interrupt |
| cpu2_rxocc_irq | output | 1 | Processor 2 RX-occupied interrupt |

## Verification
Register and flag changes land on the edge that accepts the write, and read data is registered on the edge that accepts the read. The bench therefore issues reads back to back with writes and samples the returned word on the falling edge right after the read is accepted. Interrupts trail the state they depend on by one more edge. After each write that should move an interrupt, the bench checks the old level on the falling edge right after the write, then the new level one cycle later. This confirms that the change arrives in exactly that cycle.

// File: rtl/mbox_pkg.sv
// Shared constants and types for the mailbox flag controller.
// Assumes exactly two processors and a 3-bit word address.
package mbox_pkg;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned ADDR_W   = 3;
    localparam int unsigned NUM_CPU  = 2;
    localparam int unsigned HI_LSB   = 16;  // base of upper per-channel field
    localparam int unsigned TXEN_BIT = 16;  // TX-free enable in control word
    localparam int unsigned RXEN_BIT = 0;   // RX-occupied enable in control word

    typedef enum logic [1:0] {
        ROLE_CTRL   = 2'd0,
        ROLE_MASK   = 2'd1,
        ROLE_SETCLR = 2'd2,
        ROLE_STAT   = 2'd3
    } reg_role_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;
endpackage

// File: rtl/mbox_bus_dec.sv
// Decodes one bus access into per-processor write strobes and per-direction
// flag set/clear vectors. Non-word accesses are dropped here.
// Assumes NCH <= 16 so both per-channel fields fit in one 32-bit word.
module mbox_bus_dec
    import mbox_pkg::*;
#(
    parameter int unsigned NCH = 6
) (
    input  logic                            bus_sel,
    input  logic                            bus_wr,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic [1:0]                      bus_size,
    input  logic [DATA_W-1:0]               bus_wdata,
    output logic [NUM_CPU-1:0]              wr_ctrl,
    output logic [NUM_CPU-1:0]              wr_mask,
    output logic [NUM_CPU-1:0][NCH-1:0]     set_vec,
    output logic [NUM_CPU-1:0][NCH-1:0]     clr_vec,
    output logic                            rd_acc,
    output logic                            rd_cpu,
    output reg_role_e                       rd_role
);
    logic                 word_acc;
    logic                 wr_acc;
    logic                 acc_cpu;
    reg_role_e            acc_role;
    logic [NUM_CPU-1:0]   sc_hit;
    logic                 unused_wdata;

    // Qualify the access: only full-word requests count.
    assign word_acc = bus_sel && (bus_size == SZ_WORD);
    assign wr_acc   = word_acc && bus_wr;
    assign rd_acc   = word_acc && !bus_wr;
    assign acc_cpu  = bus_addr[ADDR_W-1];
    assign acc_role = reg_role_e'(bus_addr[1:0]);
    assign rd_cpu   = acc_cpu;
    assign rd_role  = acc_role;

    // Bits outside the decoded fields are consumed here on purpose.
    assign unused_wdata = ^bus_wdata;

    generate
        for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
            // Per-processor strobes for each writable role.
            assign wr_ctrl[c] = wr_acc && (acc_cpu == 1'(c)) && (acc_role == ROLE_CTRL);
            assign wr_mask[c] = wr_acc && (acc_cpu == 1'(c)) && (acc_role == ROLE_MASK);
            assign sc_hit[c]  = wr_acc && (acc_cpu == 1'(c)) && (acc_role == ROLE_SETCLR);
        end
        for (genvar d = 0; d < NUM_CPU; d++) begin : g_dir
            // Direction d is set by its sender and cleared by the other processor.
            assign set_vec[d] = sc_hit[d] ? bus_wdata[HI_LSB +: NCH] : '0;
            assign clr_vec[d] = sc_hit[NUM_CPU-1-d] ? bus_wdata[NCH-1:0] : '0;
        end
    endgenerate
endmodule

// File: rtl/mbox_cfg_reg.sv
// Holds one processor's interrupt enables and per-channel masks.
// Masks reset to all ones (every channel masked), enables reset to zero.
module mbox_cfg_reg #(
    parameter int unsigned NCH = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_ctrl,
    input  logic           wr_mask,
    input  logic           txen_d,
    input  logic           rxen_d,
    input  logic [NCH-1:0] free_d,
    input  logic [NCH-1:0] occ_d,
    output logic           tx_en,
    output logic           rx_en,
    output logic [NCH-1:0] free_mask,
    output logic [NCH-1:0] occ_mask
);
    // Enable bits, loaded from a control-word write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en <= 1'b0;
            rx_en <= 1'b0;
        end else if (wr_ctrl) begin
            tx_en <= txen_d;
            rx_en <= rxen_d;
        end
    end

    // Channel masks, loaded from a mask-word write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_mask <= '1;
            occ_mask  <= '1;
        end else if (wr_mask) begin
            free_mask <= free_d;
            occ_mask  <= occ_d;
        end
    end
endmodule

// File: rtl/mbox_flag_bank.sv
// Channel flags of one direction. Set bits mark channels occupied and clear
// bits mark them free. A single bus write never drives both for the same bank,
// but set is given priority if it ever did.
module mbox_flag_bank #(
    parameter int unsigned NCH = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] set_vec,
    input  logic [NCH-1:0] clr_vec,
    output logic [NCH-1:0] flags
);
    // Flag update from write-one strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~clr_vec) | set_vec;
        end
    end
endmodule

// File: rtl/mbox_irq_gen.sv
// Builds one processor's two level interrupts from masked flag state.
// Outputs are registered, so they trail the flags/masks by one cycle.
module mbox_irq_gen #(
    parameter int unsigned NCH = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tx_en,
    input  logic           rx_en,
    input  logic [NCH-1:0] free_mask,
    input  logic [NCH-1:0] occ_mask,
    input  logic [NCH-1:0] tx_flags,
    input  logic [NCH-1:0] rx_flags,
    output logic           txfree_irq,
    output logic           rxocc_irq
);
    logic any_free;
    logic any_occ;

    // Reduce unmasked channel conditions.
    assign any_free = |(~tx_flags & ~free_mask);
    assign any_occ  = |(rx_flags & ~occ_mask);

    // Register the gated levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txfree_irq <= 1'b0;
            rxocc_irq  <= 1'b0;
        end else begin
            txfree_irq <= tx_en && any_free;
            rxocc_irq  <= rx_en && any_occ;
        end
    end
endmodule

// File: rtl/mbox_flag_ctrl.sv
// Top of the mailbox flag controller: bus decode, two configuration banks,
// two flag directions, two interrupt generators and the registered read mux.
// Assumes a single-cycle bus with no wait states; NCH <= 16.
module mbox_flag_ctrl
    import mbox_pkg::*;
#(
    parameter int unsigned NCH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              cpu1_txfree_irq,
    output logic              cpu1_rxocc_irq,
    output logic              cpu2_txfree_irq,
    output logic              cpu2_rxocc_irq
);
    logic [NUM_CPU-1:0]          wr_ctrl;
    logic [NUM_CPU-1:0]          wr_mask;
    logic [NUM_CPU-1:0][NCH-1:0] set_vec;
    logic [NUM_CPU-1:0][NCH-1:0] clr_vec;
    logic                        rd_acc;
    logic                        rd_cpu;
    reg_role_e                   rd_role;

    logic [NUM_CPU-1:0]          tx_en;
    logic [NUM_CPU-1:0]          rx_en;
    logic [NUM_CPU-1:0][NCH-1:0] free_mask;
    logic [NUM_CPU-1:0][NCH-1:0] occ_mask;
    logic [NUM_CPU-1:0][NCH-1:0] tx_flags;
    logic [NUM_CPU-1:0]          txfree_irq;
    logic [NUM_CPU-1:0]          rxocc_irq;
    logic [DATA_W-1:0]           rd_next;

    mbox_bus_dec #(.NCH(NCH)) u_dec (
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .wr_ctrl   (wr_ctrl),
        .wr_mask   (wr_mask),
        .set_vec   (set_vec),
        .clr_vec   (clr_vec),
        .rd_acc    (rd_acc),
        .rd_cpu    (rd_cpu),
        .rd_role   (rd_role)
    );

    generate
        for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
            mbox_cfg_reg #(.NCH(NCH)) u_cfg (
                .clk       (clk),
                .rst_n     (rst_n),
                .wr_ctrl   (wr_ctrl[c]),
                .wr_mask   (wr_mask[c]),
                .txen_d    (bus_wdata[TXEN_BIT]),
                .rxen_d    (bus_wdata[RXEN_BIT]),
                .free_d    (bus_wdata[HI_LSB +: NCH]),
                .occ_d     (bus_wdata[NCH-1:0]),
                .tx_en     (tx_en[c]),
                .rx_en     (rx_en[c]),
                .free_mask (free_mask[c]),
                .occ_mask  (occ_mask[c])
            );

            // Direction c is the transmit direction of processor c.
            mbox_flag_bank #(.NCH(NCH)) u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .set_vec (set_vec[c]),
                .clr_vec (clr_vec[c]),
                .flags   (tx_flags[c])
            );

            mbox_irq_gen #(.NCH(NCH)) u_irq (
                .clk        (clk),
                .rst_n      (rst_n),
                .tx_en      (tx_en[c]),
                .rx_en      (rx_en[c]),
                .free_mask  (free_mask[c]),
                .occ_mask   (occ_mask[c]),
                .tx_flags   (tx_flags[c]),
                .rx_flags   (tx_flags[NUM_CPU-1-c]),
                .txfree_irq (txfree_irq[c]),
                .rxocc_irq  (rxocc_irq[c])
            );
        end
    endgenerate

    // Assemble the addressed word; reserved bits and set/clear words stay 0.
    always_comb begin
        rd_next = '0;
        if (rd_acc) begin
            case (rd_role)
                ROLE_CTRL: begin
                    rd_next[TXEN_BIT] = tx_en[rd_cpu];
                    rd_next[RXEN_BIT] = rx_en[rd_cpu];
                end
                ROLE_MASK: begin
                    rd_next[HI_LSB +: NCH] = free_mask[rd_cpu];
                    rd_next[NCH-1:0]       = occ_mask[rd_cpu];
                end
                ROLE_STAT: rd_next[NCH-1:0] = tx_flags[rd_cpu];
                default:   rd_next = '0;
            endcase
        end
    end

    // Register read data for the cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= rd_next;
        end
    end

    assign cpu1_txfree_irq = txfree_irq[0];
    assign cpu1_rxocc_irq  = rxocc_irq[0];
    assign cpu2_txfree_irq = txfree_irq[1];
    assign cpu2_rxocc_irq  = rxocc_irq[1];
endmodule

// File: rtl/mbox_flag_ctrl_chk.sv
// Protocol and state checks for mbox_flag_ctrl, attached by bind.
// All properties are held off until one full cycle after reset release.
module mbox_flag_ctrl_chk
    import mbox_pkg::*;
#(
    parameter int unsigned NCH = 6
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          bus_sel,
    input logic                          bus_wr,
    input logic [2:0]                    bus_addr,
    input logic [1:0]                    bus_size,
    input logic [31:0]                   bus_wdata,
    input logic [31:0]                   bus_rdata,
    input logic [NUM_CPU-1:0][NCH-1:0]   flags,
    input logic [NUM_CPU-1:0]            tx_en,
    input logic [NUM_CPU-1:0]            rx_en,
    input logic [NUM_CPU-1:0][NCH-1:0]   free_mask,
    input logic [NUM_CPU-1:0][NCH-1:0]   occ_mask,
    input logic [NUM_CPU-1:0]            txfree_irq,
    input logic [NUM_CPU-1:0]            rxocc_irq
);
    logic past_ok;
    logic sc_wr;
    logic sc_rd;
    logic narrow_rd;
    logic unused_chk;

    // Arms the checks one cycle after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assign sc_wr     = bus_sel && bus_wr && (bus_size == SZ_WORD) && (bus_addr[1:0] == 2'd2);
    assign sc_rd     = bus_sel && !bus_wr && (bus_size == SZ_WORD) && (bus_addr[1:0] == 2'd2);
    assign narrow_rd = bus_sel && !bus_wr && (bus_size != SZ_WORD);
    assign unused_chk = ^bus_wdata;

    p_setclr_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        $past(sc_rd) |-> (bus_rdata == '0));

    p_narrow_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        $past(narrow_rd) |-> (bus_rdata == '0));

    p_flags_hold_r5: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        !$past(sc_wr) |-> $stable(flags));

    p_set_lands_cpu1_r3: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        $past(sc_wr && !bus_addr[2]) |->
            ((flags[0] & $past(bus_wdata[HI_LSB +: NCH])) == $past(bus_wdata[HI_LSB +: NCH])));

    p_set_lands_cpu2_r3: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        $past(sc_wr && bus_addr[2]) |->
            ((flags[1] & $past(bus_wdata[HI_LSB +: NCH])) == $past(bus_wdata[HI_LSB +: NCH])));

    p_clr_lands_cpu1_r4: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        $past(sc_wr && !bus_addr[2]) |-> ((flags[1] & $past(bus_wdata[NCH-1:0])) == '0));

    p_clr_lands_cpu2_r4: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        $past(sc_wr && bus_addr[2]) |-> ((flags[0] & $past(bus_wdata[NCH-1:0])) == '0));

    generate
        for (genvar c = 0; c < NUM_CPU; c++) begin : g_irq
            p_rx_irq_gated_r6: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
                $past(!rx_en[c] || (&occ_mask[c])) |-> !rxocc_irq[c]);
            p_tx_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
                $past(!tx_en[c] || (&free_mask[c])) |-> !txfree_irq[c]);
            p_rx_irq_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
                $past(flags[NUM_CPU-1-c] == '0) |-> !rxocc_irq[c]);
        end
    endgenerate
endmodule

bind mbox_flag_ctrl mbox_flag_ctrl_chk #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_size   (bus_size),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .flags      (tx_flags),
    .tx_en      (tx_en),
    .rx_en      (rx_en),
    .free_mask  (free_mask),
    .occ_mask   (occ_mask),
    .txfree_irq (txfree_irq),
    .rxocc_irq  (rxocc_irq)
);

// File: tb/test_mbox_flag_ctrl.sv
// Directed bench: one task per scenario, each checking its own results.
// Bus driven and outputs sampled on falling edges.
module test_mbox_flag_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [1:0]  bus_size = 2'd2;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cpu1_txfree_irq, cpu1_rxocc_irq, cpu2_txfree_irq, cpu2_rxocc_irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    mbox_flag_ctrl i_mbox_flag_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .cpu1_txfree_irq(cpu1_txfree_irq), .cpu1_rxocc_irq(cpu1_rxocc_irq),
        .cpu2_txfree_irq(cpu2_txfree_irq), .cpu2_rxocc_irq(cpu2_rxocc_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr_sz(input logic [2:0] a, input logic [31:0] d, input logic [1:0] sz);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_size = 2'd2;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_sz(a, d, 2'd2);
    endtask

    task automatic rd_sz(input logic [2:0] a, input logic [1:0] sz, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_size = sz;
        @(negedge clk);
        bus_sel = 1'b0; bus_size = 2'd2;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd_sz(a, 2'd2, v);
        chk(tag, v, exp);
    endtask

    function automatic logic [31:0] irqs();
        return {28'b0, cpu2_rxocc_irq, cpu2_txfree_irq, cpu1_rxocc_irq, cpu1_txfree_irq};
    endfunction

    // R1, R2: reset values of all eight words and the interrupts.
    task automatic t_reset();
        chk("R1 irqs after reset", irqs(), 32'h0);
        for (int c = 0; c < 2; c++) begin
            rd_chk("R1 ctrl reset",   3'(4*c + 0), 32'h0);
            rd_chk("R1 mask reset",   3'(4*c + 1), 32'h003F_003F);
            rd_chk("R1 setclr reset", 3'(4*c + 2), 32'h0);
            rd_chk("R1 status reset", 3'(4*c + 3), 32'h0);
        end
    endtask

    // R3, R4, R10: directional set/clear, read back in the next cycle.
    task automatic t_set_clear();
        wr(3'd2, 32'h0005_0000);
        rd_chk("R3 R10 cpu1 sets ch1,ch3", 3'd3, 32'h5);
        rd_chk("R3 other direction untouched", 3'd7, 32'h0);
        wr(3'd6, 32'h0000_0001);
        rd_chk("R4 cpu2 clears ch1 of 1to2", 3'd3, 32'h4);
        wr(3'd6, 32'h0022_0000);
        rd_chk("R3 cpu2 sets ch2,ch6", 3'd7, 32'h22);
        wr(3'd2, 32'h0000_0020);
        rd_chk("R4 cpu1 clears ch6 of 2to1", 3'd7, 32'h2);
        wr(3'd2, 32'h0000_0004);
        rd_chk("R4 clear never hits own tx", 3'd3, 32'h4);
        wr(3'd2, 32'h0001_0002);
        rd_chk("R4 combined set half", 3'd3, 32'h5);
        rd_chk("R4 combined clear half", 3'd7, 32'h0);
        wr(3'd6, 32'h0000_003F);
        rd_chk("R4 cleanup", 3'd3, 32'h0);
    endtask

    // R5, R4: status read-only, set/clear reads zero, zero bits do nothing.
    task automatic t_readonly();
        wr(3'd3, 32'hFFFF_FFFF);
        wr(3'd7, 32'hFFFF_FFFF);
        rd_chk("R5 status1 write ignored", 3'd3, 32'h0);
        rd_chk("R5 status2 write ignored", 3'd7, 32'h0);
        wr(3'd2, 32'h0001_0000);
        wr(3'd6, 32'h0000_0000);
        rd_chk("R4 zero write no effect", 3'd3, 32'h1);
        rd_chk("R5 setclr1 reads zero", 3'd2, 32'h0);
        rd_chk("R5 setclr2 reads zero", 3'd6, 32'h0);
        wr(3'd6, 32'h0000_0001);
    endtask

    // R6, R10: processor 2 RX-occupied interrupt.
    task automatic t_rx_irq();
        wr(3'd4, 32'h0000_0001);
        wr(3'd5, 32'h003F_003E);
        wr(3'd2, 32'h0002_0000);
        @(negedge clk);
        chk("R6 masked channel no irq", {31'b0, cpu2_rxocc_irq}, 32'h0);
        wr(3'd2, 32'h0001_0000);
        chk("R10 irq not yet after write", {31'b0, cpu2_rxocc_irq}, 32'h0);
        @(negedge clk);
        chk("R6 R10 rx irq rises", {31'b0, cpu2_rxocc_irq}, 32'h1);
        chk("R6 cpu1 rx irq idle", {31'b0, cpu1_rxocc_irq}, 32'h0);
        wr(3'd5, 32'h003F_003F);
        @(negedge clk);
        chk("R6 masking drops irq", {31'b0, cpu2_rxocc_irq}, 32'h0);
        wr(3'd5, 32'h003F_003E);
        @(negedge clk);
        chk("R6 unmask restores irq", {31'b0, cpu2_rxocc_irq}, 32'h1);
        wr(3'd4, 32'h0);
        @(negedge clk);
        chk("R6 disable drops irq", {31'b0, cpu2_rxocc_irq}, 32'h0);
        wr(3'd6, 32'h0000_0003);
        wr(3'd5, 32'h003F_003F);
    endtask

    // R7: processor 1 TX-free interrupt.
    task automatic t_tx_irq();
        wr(3'd0, 32'h0001_0000);
        wr(3'd1, 32'h003B_003F);
        @(negedge clk);
        chk("R7 free ch3 raises irq", {31'b0, cpu1_txfree_irq}, 32'h1);
        chk("R7 cpu2 tx irq idle", {31'b0, cpu2_txfree_irq}, 32'h0);
        wr(3'd2, 32'h0004_0000);
        @(negedge clk);
        chk("R7 occupied drops irq", {31'b0, cpu1_txfree_irq}, 32'h0);
        wr(3'd6, 32'h0000_0004);
        @(negedge clk);
        chk("R7 freed again raises irq", {31'b0, cpu1_txfree_irq}, 32'h1);
        wr(3'd0, 32'h0);
        @(negedge clk);
        chk("R7 disable drops irq", {31'b0, cpu1_txfree_irq}, 32'h0);
        wr(3'd1, 32'h003F_003F);
    endtask

    // R8: narrow accesses ignored, read as zero.
    task automatic t_narrow();
        logic [31:0] v;
        wr_sz(3'd0, 32'h0001_0001, 2'd0);
        rd_chk("R8 byte write to ctrl ignored", 3'd0, 32'h0);
        wr_sz(3'd2, 32'h0001_0000, 2'd1);
        rd_chk("R8 half write to setclr ignored", 3'd3, 32'h0);
        wr(3'd2, 32'h0001_0000);
        rd_sz(3'd3, 2'd1, v);
        chk("R8 half read returns zero", v, 32'h0);
        rd_chk("R8 word read sees flag", 3'd3, 32'h1);
        rd_sz(3'd1, 2'd0, v);
        chk("R8 byte read returns zero", v, 32'h0);
        wr(3'd6, 32'h0000_0001);
    endtask

    // R9: reserved bits.
    task automatic t_reserved();
        wr(3'd0, 32'hFFFF_FFFF);
        rd_chk("R9 ctrl reserved bits", 3'd0, 32'h0001_0001);
        wr(3'd5, 32'hFFFF_FFFF);
        rd_chk("R9 mask reserved bits", 3'd5, 32'h003F_003F);
        chk("R9 all masked no irq", irqs(), 32'h0);
        wr(3'd0, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set_clear();
        t_readonly();
        t_rx_irq();
        t_tx_irq();
        t_narrow();
        t_reserved();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule